// File: doc/BRIEF.md
# GF(2^8) Field Multiplier with Polynomial Reduction

This block multiplies two elements of the binary extension field of 256 elements. The field is built on the irreducible polynomial x^8+x^4+x^3+x+1, written 0x11B. The datapath is purely combinational and has two stages. The first stage forms the 15-bit carry-less polynomial product of the two operands. The second stage folds that product back into 8 bits by removing multiples of the field polynomial. The same operands also drive a field-sum output, which is a bitwise XOR.

A parameter selects the structure of the product stage. One choice is a schoolbook array of AND terms and XOR trees. The other is a recursive three-way split that saves AND gates at the cost of extra XORs. The reduction stage is the same for both choices. The unreduced product is also brought out, so that an integrator can reuse it or check it.

Top module: `gf8_field_mul`

## Requirements
- R1: `sum_o` equals `a_i` XOR `b_i` for every operand pair; for example 0x53 and 0xCA give 0x99.
- R2: `prod_o` equals the remainder of the polynomial product of `a_i` and `b_i` modulo 0x11B, for every one of the 65536 operand pairs.
- R3: Operands 0x53 and 0xCA give `prod_o` = 0x01.
- R4: `raw_o` is the 15-bit carry-less product, where bit k is the XOR of all a[i]&b[j] with i+j=k. For 0x53 and 0xCA this is 0x3F7E (binary 11111101111110).
- R5: If either operand is 0x01, `prod_o` equals the other operand.
- R6: If either operand is 0x00, `prod_o` is 0x00.
- R7: If `raw_o` has no bit set at position 8 or above, `prod_o` equals `raw_o[7:0]`. For example, 0x10 times 0x08 gives 0x80.
- R8: Folding works from the top bit down. For example, 0x80 times 0x02 gives raw 0x0100 and `prod_o` = 0x1B.
- R9: The schoolbook and split product structures give identical `raw_o`, `prod_o` and `sum_o` for every operand pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 8 | First field operand |
| b_i | input | 8 | Second field operand |
| prod_o | output | 8 | Reduced field product |
| sum_o | output | 8 | Field sum (bitwise XOR) |
| raw_o | output | 15 | Unreduced carry-less product |

## Verification
The field sum and the reduced product come from the same operand pair in the same cycle. Every operand pair that is applied therefore judges both functions at once: the sum against an arithmetic XOR, and the product against a shift-and-conditional-fold model computed in the bench. A sweep over all 65536 pairs drives two instances side by side, one with each product structure. Each sampled result is compared with the bench models and with the other instance. Directed pairs pin the identity, zero, pass-through and single-fold corners before the sweep starts.

// File: rtl/gf8_pkg.sv
package gf8_pkg;
   typedef enum logic [0:0] {
      CLMUL_SCHOOL = 1'b0,
      CLMUL_SPLIT  = 1'b1
   } clmul_arch_e;

   localparam int unsigned FIELD_W_DEF = 8;
   localparam logic [8:0]  FIELD_POLY_DEF = 9'h11B;
endpackage

// File: rtl/gf_clmul_school.sv
module gf_clmul_school #(
   parameter int unsigned N = 8
) (
   input  logic [N-1:0]   a_i,
   input  logic [N-1:0]   b_i,
   output logic [2*N-2:0] c_o
);
   localparam int unsigned PW = 2 * N - 1;

   if (N < 1) begin : g_bad_width
      $error("gf_clmul_school: N must be at least 1");
   end

   logic [PW-1:0] row [0:N];
   assign row[0] = '0;

   for (genvar i = 0; i < N; i++) begin : g_row
      logic [PW-1:0] shifted;
      assign shifted  = PW'(a_i) << i;
      assign row[i+1] = row[i] ^ (shifted & {PW{b_i[i]}});
   end

   assign c_o = row[N];

   always_comb begin
      // R4
      school_lsb_chk: assert (c_o[0] == (a_i[0] & b_i[0]));
      // R4
      school_msb_chk: assert (c_o[PW-1] == (a_i[N-1] & b_i[N-1]));
   end
endmodule

// File: rtl/gf_clmul_split.sv
module gf_clmul_split #(
   parameter int unsigned N = 8
) (
   input  logic [N-1:0]   a_i,
   input  logic [N-1:0]   b_i,
   output logic [2*N-2:0] c_o
);
   localparam int unsigned PW = 2 * N - 1;
   localparam int unsigned L  = N / 2;
   localparam int unsigned H  = N - L;
   localparam int unsigned LW = (L > 0) ? 2 * L - 1 : 1;
   localparam int unsigned HW = 2 * H - 1;

   if (N < 1) begin : g_bad_width
      $error("gf_clmul_split: N must be at least 1");
   end

   if (N == 1) begin : g_leaf
      assign c_o = a_i & b_i;
   end else begin : g_node
      logic [L-1:0]  a_lo, b_lo;
      logic [H-1:0]  a_hi, b_hi, a_mix, b_mix;
      logic [LW-1:0] p_lo;
      logic [HW-1:0] p_hi, p_mix, p_cross;

      assign a_lo  = a_i[L-1:0];
      assign b_lo  = b_i[L-1:0];
      assign a_hi  = a_i[N-1:L];
      assign b_hi  = b_i[N-1:L];
      assign a_mix = a_hi ^ H'(a_lo);
      assign b_mix = b_hi ^ H'(b_lo);

      gf_clmul_split #(.N(L)) u_lo  (.a_i(a_lo),  .b_i(b_lo),  .c_o(p_lo));
      gf_clmul_split #(.N(H)) u_hi  (.a_i(a_hi),  .b_i(b_hi),  .c_o(p_hi));
      gf_clmul_split #(.N(H)) u_mix (.a_i(a_mix), .b_i(b_mix), .c_o(p_mix));

      assign p_cross = p_mix ^ p_hi ^ HW'(p_lo);
      assign c_o = PW'(p_lo) ^ (PW'(p_hi) << (2 * L)) ^ (PW'(p_cross) << L);

      always_comb begin
         // R4
         split_lsb_chk: assert (c_o[0] == (a_i[0] & b_i[0]));
         // R4
         split_msb_chk: assert (c_o[PW-1] == (a_i[N-1] & b_i[N-1]));
      end
   end
endmodule

// File: rtl/gf_reduce.sv
module gf_reduce #(
   parameter int unsigned W    = 8,
   parameter logic [W:0]  POLY = 9'h11B
) (
   input  logic [2*W-2:0] raw_i,
   output logic [W-1:0]   rem_o
);
   localparam int unsigned PW    = 2 * W - 1;
   localparam int unsigned STEPS = W - 1;

   if (W < 2) begin : g_bad_width
      $error("gf_reduce: W must be at least 2");
   end
   if (POLY[W] != 1'b1 || POLY[0] != 1'b1) begin : g_bad_poly
      $error("gf_reduce: POLY needs its top and constant terms set");
   end

   logic [PW-1:0] stage [0:STEPS];
   assign stage[0] = raw_i;

   // walk from the highest product bit down to bit W
   for (genvar k = 0; k < STEPS; k++) begin : g_fold
      localparam int unsigned TOP = PW - 1 - k;
      logic [PW-1:0] fold_mask;
      assign fold_mask  = PW'(POLY) << (TOP - W);
      assign stage[k+1] = stage[k][TOP] ? (stage[k] ^ fold_mask) : stage[k];
   end

   assign rem_o = stage[STEPS][W-1:0];

   always_comb begin
      // R2
      fold_clear_chk: assert (stage[STEPS][PW-1:W] == '0);
      // R7
      if (raw_i[PW-1:W] == '0) begin
         pass_through_chk: assert (rem_o == raw_i[W-1:0]);
      end
   end
endmodule

// File: rtl/gf8_field_mul.sv
module gf8_field_mul #(
   parameter int unsigned          W    = gf8_pkg::FIELD_W_DEF,
   parameter logic [W:0]           POLY = gf8_pkg::FIELD_POLY_DEF,
   parameter gf8_pkg::clmul_arch_e ARCH = gf8_pkg::CLMUL_SPLIT
) (
   input  logic [W-1:0]   a_i,
   input  logic [W-1:0]   b_i,
   output logic [W-1:0]   prod_o,
   output logic [W-1:0]   sum_o,
   output logic [2*W-2:0] raw_o
);
   localparam int unsigned PW = 2 * W - 1;

   if (W < 2) begin : g_bad_width
      $error("gf8_field_mul: W must be at least 2");
   end

   logic [PW-1:0] clmul;

   if (ARCH == gf8_pkg::CLMUL_SCHOOL) begin : g_school
      gf_clmul_school #(.N(W)) u_clmul (.a_i(a_i), .b_i(b_i), .c_o(clmul));
   end else begin : g_split
      gf_clmul_split  #(.N(W)) u_clmul (.a_i(a_i), .b_i(b_i), .c_o(clmul));
   end

   gf_reduce #(.W(W), .POLY(POLY)) u_reduce (.raw_i(clmul), .rem_o(prod_o));

   assign raw_o = clmul;
   assign sum_o = a_i ^ b_i;

   always_comb begin
      // R1
      sum_cancel_chk: assert ((sum_o ^ a_i) == b_i);
      // R5
      if (b_i == W'(1)) begin
         unit_right_chk: assert (prod_o == a_i);
      end
      // R5
      if (a_i == W'(1)) begin
         unit_left_chk: assert (prod_o == b_i);
      end
      // R6
      if (a_i == '0 || b_i == '0) begin
         zero_absorb_chk: assert (prod_o == '0 && raw_o == '0);
      end
   end
endmodule

// File: tb/tb_gf8_field_mul.sv
module tb_gf8_field_mul;
   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic [7:0]  a, b;
   logic [7:0]  prod_s, sum_s, prod_k, sum_k;
   logic [14:0] raw_s, raw_k;
   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   gf8_field_mul #(.ARCH(gf8_pkg::CLMUL_SPLIT)) dut (
      .a_i(a), .b_i(b), .prod_o(prod_k), .sum_o(sum_k), .raw_o(raw_k));
   gf8_field_mul #(.ARCH(gf8_pkg::CLMUL_SCHOOL)) dut_s (
      .a_i(a), .b_i(b), .prod_o(prod_s), .sum_o(sum_s), .raw_o(raw_s));

   function automatic logic [7:0] ref_mul(input logic [7:0] x, input logic [7:0] y);
      logic [7:0] acc = 8'h00;
      logic [7:0] sh = x;
      for (int i = 0; i < 8; i++) begin
         if (y[i]) acc ^= sh;
         sh = sh[7] ? ((sh << 1) ^ 8'h1B) : (sh << 1);
      end
      return acc;
   endfunction

   function automatic logic [14:0] ref_raw(input logic [7:0] x, input logic [7:0] y);
      logic [14:0] acc = '0;
      for (int i = 0; i < 8; i++)
         if (y[i]) acc ^= (15'(x) << i);
      return acc;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s a=%02h b=%02h actual=%0h expected=%0h", req, a, b, act, exp);
      end
   endtask

   task automatic apply(input logic [7:0] x, input logic [7:0] y);
      @(posedge clk);
      a = x;
      b = y;
      @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   endtask

   initial begin
      a = 8'h00;
      b = 8'h00;
      @(negedge clk);
      // zero inputs at start: all outputs idle at zero (R6, R1)
      chk(prod_k == 8'h00, "R6", prod_k, 0);
      chk(sum_k == 8'h00, "R1", sum_k, 0);

      apply(8'h53, 8'hCA);
      chk(sum_k == 8'h99, "R1", sum_k, 8'h99);
      chk(prod_k == 8'h01, "R3", prod_k, 1);
      chk(raw_k == 15'h3F7E, "R4", raw_k, 15'h3F7E);
      chk(prod_s == 8'h01, "R3", prod_s, 1);

      apply(8'hB7, 8'h01);
      chk(prod_k == 8'hB7, "R5", prod_k, 8'hB7);
      apply(8'h01, 8'hE4);
      chk(prod_k == 8'hE4, "R5", prod_k, 8'hE4);
      apply(8'h00, 8'hFF);
      chk(prod_k == 8'h00, "R6", prod_k, 0);
      apply(8'h10, 8'h08);
      chk(prod_k == 8'h80, "R7", prod_k, 8'h80);
      apply(8'h80, 8'h02);
      chk(raw_k == 15'h0100, "R8", raw_k, 15'h0100);
      chk(prod_k == 8'h1B, "R8", prod_k, 8'h1B);
      apply(8'hFF, 8'hFF);
      chk(prod_k == ref_mul(8'hFF, 8'hFF), "R8", prod_k, ref_mul(8'hFF, 8'hFF));

      for (int x = 0; x < 256; x++) begin
         for (int y = 0; y < 256; y++) begin
            apply(8'(x), 8'(y));
            chk(prod_k == ref_mul(a, b), "R2", prod_k, ref_mul(a, b));
            chk(raw_k == ref_raw(a, b), "R4", raw_k, ref_raw(a, b));
            chk(sum_k == (a ^ b), "R1", sum_k, a ^ b);
            chk(prod_s == prod_k && raw_s == raw_k && sum_s == sum_k, "R9",
                {prod_s, raw_s}, {prod_k, raw_k});
            if (raw_k[14:8] == 7'h00)
               chk(prod_k == raw_k[7:0], "R7", prod_k, raw_k[7:0]);
         end
      end
      finish_run();
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
      finish_run();
   end
endmodule